// File: doc/BRIEF.md
# Serial Memory Power-State Sequencer

This block decides when a serial nonvolatile memory may be selected. It walks the device through five power states: a lockout after power-up, normal operation, a timed descent into sleep, sleep itself, and a timed climb back out. All windows are counted on a free-running reference clock. The window lengths are given in microseconds and scaled by a ticks-per-microsecond parameter, so a testbench can make them short.

The SPI front-end shifts the opcode bits. For every bit it receives it pulses `bit_strobe`, and it raises `cmd_sleep` (opcode B9h) or `cmd_wake` (opcode ABh) in the cycle of the opcode's last bit. The sequencer arms the matching transition and carries it out only when chip select rises with no further bit clocked after the opcode. Its outputs tell the front-end whether a selection is allowed at all and whether only the wake opcode may be honoured.

A chip-select falling edge during the power-up lockout or the wake window is a protocol error. The sequencer sets a sticky flag that only reset clears. A selection that starts while selection is refused is ignored in full. Reset models a power cycle: the block always comes back through the lockout into normal operation, even if it was asleep.

Top module: `mram_pwr_seq`

## Requirements
- R1: During and after reset the state is LOCKOUT, `accept_o`=0 and `viol_o`=0. After LOCKOUT_US×TICKS_PER_US clock edges past reset release the state becomes ACTIVE.
- R2: `state_o` encodes LOCKOUT=0, ACTIVE=1, ENTER=2, ASLEEP=3, WAKING=4. `accept_o` is 1 exactly in ACTIVE and ASLEEP. `wake_only_o` is 1 exactly in ASLEEP.
- R3: In ACTIVE, a selection that carries `cmd_sleep` and ends with a chip-select rise moves the state to ENTER on the edge that samples `cs_n` high.
- R4: ENTER lasts SLEEP_ENTRY_US×TICKS_PER_US edges and then becomes ASLEEP.
- R5: A `bit_strobe` in the same cycle as the command pulse counts as the opcode's last bit. Any later `bit_strobe` before chip select rises cancels the command, and the state does not change.
- R6: In ASLEEP, `cmd_sleep` has no effect. A completed `cmd_wake` selection moves the state to WAKING.
- R7: WAKING lasts WAKE_EXIT_US×TICKS_PER_US edges and then becomes ACTIVE.
- R8: A `cs_n` falling edge in LOCKOUT or WAKING sets `viol_o` one edge later. The flag stays set until reset, and the window length is unchanged.
- R9: In ACTIVE, a completed `cmd_wake` selection has no effect.
- R10: A reset applied while ASLEEP returns the block through LOCKOUT to ACTIVE, not to ASLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Chip-select level, synchronous to clk_ref |
| bit_strobe | input | 1 | One-cycle pulse per serial bit received |
| cmd_sleep | input | 1 | Sleep opcode decoded (last opcode bit) |
| cmd_wake | input | 1 | Wake opcode decoded (last opcode bit) |
| accept_o | output | 1 | Selection is allowed |
| wake_only_o | output | 1 | Only the wake opcode may be honoured |
| state_o | output | 3 | Power-state code |
| viol_o | output | 1 | Sticky: selection attempted in a refused window |

## Verification
The front-end reports the opcode's last bit and the decoded command in the same cycle. Arming and disarming therefore coincide on every command selection. The bench drives this overlap in every transaction and expects the command to arm. A single extra bit after the command must then cancel the transition, which is judged at the chip-select rise. A second collision is a chip-select fall inside the wake window and inside the power-up lockout. There the bench expects the flag one edge later, with the window's exit edge unchanged.

// File: rtl/mram_pwr_pkg.sv
package mram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_LOCKOUT = 3'd0,
        PS_ACTIVE  = 3'd1,
        PS_ENTER   = 3'd2,
        PS_ASLEEP  = 3'd3,
        PS_WAKING  = 3'd4
    } pwr_state_t;

endpackage

// File: rtl/mram_pwr_edge.sv
module mram_pwr_edge (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_fall,
    output logic cs_rise
);
    logic cs_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    assign cs_fall = cs_q & ~cs_n;
    assign cs_rise = ~cs_q & cs_n;

    // R8: an edge event needs an actual level change on cs_n
    a_r8_fall_needs_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cs_fall |=> $past(cs_n) == 1'b0);
endmodule

// File: rtl/mram_pwr_timer.sv
module mram_pwr_timer #(
    parameter int CW = 16
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == limit - 1'b1);

    // R4, R7: a running window never counts past its length
    a_r4_cnt_in_window: assert property (@(posedge clk_ref) disable iff (!rst_n)
        en |-> cnt_q < limit);
endmodule

// File: rtl/mram_pwr_arm.sv
module mram_pwr_arm (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic accept,
    input  logic sleep_ok,
    input  logic wake_ok,
    input  logic bit_strobe,
    input  logic cmd_sleep,
    input  logic cmd_wake,
    output logic go_sleep,
    output logic go_wake
);
    logic sel_q;
    logic arm_s_q, arm_w_q;

    // selection is honoured only if it began while selection was accepted
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)       sel_q <= 1'b0;
        else if (cs_rise) sel_q <= 1'b0;
        else if (cs_fall) sel_q <= accept;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            arm_s_q <= 1'b0;
            arm_w_q <= 1'b0;
        end else if (cs_rise || cs_fall) begin
            arm_s_q <= 1'b0;
            arm_w_q <= 1'b0;
        end else if (cmd_sleep && sel_q && sleep_ok) begin
            arm_s_q <= 1'b1;
            arm_w_q <= 1'b0;
        end else if (cmd_wake && sel_q && wake_ok) begin
            arm_s_q <= 1'b0;
            arm_w_q <= 1'b1;
        end else if (bit_strobe) begin
            arm_s_q <= 1'b0;
            arm_w_q <= 1'b0;
        end
    end

    assign go_sleep = cs_rise & arm_s_q;
    assign go_wake  = cs_rise & arm_w_q;

    // R5: a bit after the opcode, with no command in that cycle, cancels
    a_r5_strobe_disarms: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (bit_strobe && !cmd_sleep && !cmd_wake) |=> !go_sleep && !go_wake);
endmodule

// File: rtl/mram_pwr_seq.sv
module mram_pwr_seq
    import mram_pwr_pkg::*;
#(
    parameter int TICKS_PER_US   = 100,
    parameter int LOCKOUT_US     = 400,
    parameter int SLEEP_ENTRY_US = 3,
    parameter int WAKE_EXIT_US   = 400
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       bit_strobe,
    input  logic       cmd_sleep,
    input  logic       cmd_wake,
    output logic       accept_o,
    output logic       wake_only_o,
    output logic [2:0] state_o,
    output logic       viol_o
);
    localparam int PU_T  = LOCKOUT_US * TICKS_PER_US;
    localparam int DP_T  = SLEEP_ENTRY_US * TICKS_PER_US;
    localparam int RDP_T = WAKE_EXIT_US * TICKS_PER_US;
    localparam int MAX_A = (PU_T > DP_T) ? PU_T : DP_T;
    localparam int MAX_T = (MAX_A > RDP_T) ? MAX_A : RDP_T;
    localparam int CW    = $clog2(MAX_T + 1);

    pwr_state_t    state_q, state_d;
    logic          cs_fall, cs_rise;
    logic          go_sleep, go_wake;
    logic          tmr_en, tmr_done;
    logic [CW-1:0] tmr_limit;
    logic          viol_q;

    mram_pwr_edge u_edge (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise)
    );

    mram_pwr_arm u_arm (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .accept     (accept_o),
        .sleep_ok   (state_q == PS_ACTIVE),
        .wake_ok    (state_q == PS_ASLEEP),
        .bit_strobe (bit_strobe),
        .cmd_sleep  (cmd_sleep),
        .cmd_wake   (cmd_wake),
        .go_sleep   (go_sleep),
        .go_wake    (go_wake)
    );

    mram_pwr_timer #(.CW(CW)) u_timer (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .en      (tmr_en),
        .limit   (tmr_limit),
        .done    (tmr_done)
    );

    // window selection per timed state
    always_comb begin
        tmr_en    = 1'b1;
        tmr_limit = CW'(1);
        unique case (state_q)
            PS_LOCKOUT: tmr_limit = CW'(PU_T);
            PS_ENTER:   tmr_limit = CW'(DP_T);
            PS_WAKING:  tmr_limit = CW'(RDP_T);
            default:    tmr_en    = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_LOCKOUT: if (tmr_done) state_d = PS_ACTIVE;
            PS_ACTIVE:  if (go_sleep) state_d = PS_ENTER;
            PS_ENTER:   if (tmr_done) state_d = PS_ASLEEP;
            PS_ASLEEP:  if (go_wake)  state_d = PS_WAKING;
            PS_WAKING:  if (tmr_done) state_d = PS_ACTIVE;
            default:                  state_d = PS_LOCKOUT;
        endcase
    end

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= PS_LOCKOUT;
        else        state_q <= state_d;
    end

    // sticky protocol-violation flag
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
            viol_q <= 1'b0;
        else if (cs_fall && (state_q == PS_LOCKOUT || state_q == PS_WAKING))
            viol_q <= 1'b1;
    end

    // outputs
    always_comb begin
        state_o     = state_q;
        accept_o    = (state_q == PS_ACTIVE) || (state_q == PS_ASLEEP);
        wake_only_o = (state_q == PS_ASLEEP);
        viol_o      = viol_q;
    end

    a_r3_sleep_via_entry: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == PS_ACTIVE) |=> (state_q != PS_ASLEEP));
    a_r3_go_sleep_enters: assert property (@(posedge clk_ref) disable iff (!rst_n)
        go_sleep |=> (state_q == PS_ENTER));
    a_r6_asleep_exits_to_wake: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == PS_ASLEEP) |=> (state_q == PS_ASLEEP || state_q == PS_WAKING));
    a_r7_waking_exits_active: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == PS_WAKING) |=> (state_q == PS_WAKING || state_q == PS_ACTIVE));
    a_r8_viol_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
        viol_q |=> viol_q);
    a_r8_flag_in_wake: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cs_fall && state_q == PS_WAKING) |=> viol_q);
endmodule

// File: tb/mram_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module mram_pwr_seq_tb_top;
    localparam logic [2:0] S_LOCK = 3'd0, S_ACT = 3'd1, S_ENT = 3'd2,
                           S_SLP = 3'd3, S_WAK = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
    logic bit_strobe = 1'b0, cmd_sleep = 1'b0, cmd_wake = 1'b0;
    logic accept_o, wake_only_o, viol_o;
    logic [2:0] state_o;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // windows: lockout 10, entry 4, wake 8 edges
    mram_pwr_seq #(.TICKS_PER_US(2), .LOCKOUT_US(5), .SLEEP_ENTRY_US(2),
                   .WAKE_EXIT_US(4)) dut_i (
        .clk_ref(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_strobe(bit_strobe),
        .cmd_sleep(cmd_sleep), .cmd_wake(cmd_wake), .accept_o(accept_o),
        .wake_only_o(wake_only_o), .state_o(state_o), .viol_o(viol_o));

    typedef struct { string tag; logic [2:0] st; logic v; } exp_t;
    exp_t sb_q[$];

    // expectation for the outputs after the coming clock edge
    task automatic push(string tag, logic [2:0] st, logic v);
        exp_t e;
        e.tag = tag; e.st = st; e.v = v;
        sb_q.push_back(e);
    endtask

    task automatic span(string tag, int n, logic [2:0] mid, logic [2:0] fin, logic v);
        for (int i = 1; i <= n; i++) begin
            if (i == n - 1) push(tag, mid, v);
            if (i == n)     push(tag, fin, v);
            @(negedge clk);
        end
    endtask

    // one selection: 8 opcode bits (command on the 8th), extra bits, then cs_n high
    task automatic xact(bit s, bit w, int extra);
        cs_n = 1'b0;
        @(negedge clk);
        for (int b = 0; b < 8 + extra; b++) begin
            bit_strobe = 1'b1;
            cmd_sleep  = s && (b == 7);
            cmd_wake   = w && (b == 7);
            @(negedge clk);
        end
        bit_strobe = 1'b0; cmd_sleep = 1'b0; cmd_wake = 1'b0;
        cs_n = 1'b1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: compare outputs shortly after each edge
    initial begin
        exp_t e;
        logic ea, ew;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() != 0) begin
                e  = sb_q.pop_front();
                ea = (e.st == S_ACT) || (e.st == S_SLP);
                ew = (e.st == S_SLP);
                checks++;
                if (state_o !== e.st || accept_o !== ea || wake_only_o !== ew || viol_o !== e.v) begin
                    fails++;
                    $display("FAIL %s: state=%0d accept=%0b wake_only=%0b viol=%0b expected state=%0d accept=%0b wake_only=%0b viol=%0b",
                             e.tag, state_o, accept_o, wake_only_o, viol_o, e.st, ea, ew, e.v);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

    initial begin
        @(negedge clk);
        push("R1 R2 reset state", S_LOCK, 1'b0);            // R1
        @(negedge clk);
        rst_n = 1'b1;
        span("R1 lockout end", 10, S_LOCK, S_ACT, 1'b0);     // R1

        xact(1'b0, 1'b1, 0);                                 // R9 wake while active
        span("R9 wake ignored", 2, S_ACT, S_ACT, 1'b0);

        xact(1'b1, 1'b0, 1);                                 // R5 extra bit cancels
        span("R5 cancelled sleep", 2, S_ACT, S_ACT, 1'b0);

        xact(1'b1, 1'b0, 0);                                 // R3 sleep, R5 same-cycle arm
        span("R3 R5 sleep entry", 2, S_ENT, S_ENT, 1'b0);
        span("R4 entry window", 3, S_ENT, S_SLP, 1'b0);      // R4

        xact(1'b1, 1'b0, 0);                                 // R6 sleep while asleep
        span("R6 sleep ignored", 2, S_SLP, S_SLP, 1'b0);

        xact(1'b0, 1'b1, 0);                                 // R6 wake
        span("R6 wake start", 2, S_WAK, S_WAK, 1'b0);
        span("R7 wake window", 7, S_WAK, S_ACT, 1'b0);       // R7

        xact(1'b1, 1'b0, 0);
        span("R3 second entry", 5, S_ENT, S_SLP, 1'b0);
        xact(1'b0, 1'b1, 0);
        push("R8 wake start", S_WAK, 1'b0);
        @(negedge clk);
        cs_n = 1'b0;
        push("R8 cs low in wake", S_WAK, 1'b1);              // R8
        @(negedge clk);
        cs_n = 1'b1;
        span("R8 sticky, window kept", 7, S_WAK, S_ACT, 1'b1);

        xact(1'b1, 1'b0, 0);
        span("R3 third entry", 5, S_ENT, S_SLP, 1'b1);
        rst_n = 1'b0;                                        // R10 power loss while asleep
        push("R10 reset while asleep", S_LOCK, 1'b0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cs_n  = 1'b0;
        push("R8 cs low in lockout", S_LOCK, 1'b1);          // R8
        @(negedge clk);
        cs_n = 1'b1;
        span("R10 back to active", 9, S_LOCK, S_ACT, 1'b1);  // R10

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        report();
    end
endmodule